// File: doc/BRIEF.md
# Debug Cross Trigger Interface

This block joins a set of debug components to a four-channel trigger broadcast network. Eight trigger input lines come in from the attached components. Each input has a programmable channel mask. When an input is asserted, the block raises every channel that the input's mask selects. All inputs that select the same channel are ORed together, and the result is sent to the channel matrix as outgoing channel events. Channel events that come back from the matrix drive eight trigger outputs. Each output has its own channel mask and latches high when any channel it selects carries an event.

A per-channel gate can close selected channels in both directions without touching the masks, so reopening a channel brings back the routing that was there before. Software uses a small memory-mapped register port to set the masks, the gate and a global enable. Through the same port it acknowledges latched outputs and injects single-cycle events on chosen channels.

A typical setup maps a core's halted status onto one channel. On another instance, that same channel drives a debug request output, so a halt on one core stops a second core. Everything runs on one clock.

Top module: `xtrig_iface`

## Requirements
- R1: After reset the enable bit reads 0, the gate reads 4'hF (all channels open), every input and output mask reads 0, and `chanOut` and `trigOut` are 0.
- R2: At each rising edge with the block enabled, `chanOut[c]` takes the OR over all inputs i of (`trigIn[i]` AND bit c of input mask i), ORed with any software pulse on c, then ANDed with gate bit c. The result is visible one cycle after the inputs are applied.
- R3: Incoming events are formed as (`chanIn` OR software pulse) AND gate. Output j is set at the next edge when any of these events falls in output mask j.
- R4: A trigger output stays high until a write to offset 0x08 has a 1 in bit j. Writing 0 bits leaves it unchanged. If a new set and an acknowledge arrive in the same cycle, the set wins.
- R5: A gate bit of 0 (offset 0x04, bit c = channel c) blocks channel c both outgoing and incoming. The mask registers keep their values, and reopening the gate restores the earlier routing.
- R6: While the enable bit (offset 0x00, bit 0) is 0, `chanOut` and `trigOut` are 0 from the next edge on, and all latched outputs are cleared.
- R7: Writing to offset 0x0C with bit c set produces exactly one cycle of event on channel c. That event goes out on `chanOut` and also feeds the output masks, subject to the gate and the enable.
- R8: The register map is as follows. Input mask i is at 0x20+4i and output mask j is at 0x40+4j, with bits [3:0] holding channels 3..0. Offset 0x60 reads the raw `trigIn` value and offset 0x64 reads `trigOut`. `regRdata` is combinational from `regAddr`.
- R9: Writes to the read-only offsets 0x60 and 0x64 change no state. Offsets 0x08 and 0x0C always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational |
| trigIn | input | 8 | Trigger inputs from debug components |
| trigOut | output | 8 | Latched trigger outputs |
| chanIn | input | 4 | Channel events from the matrix |
| chanOut | output | 4 | Channel events to the matrix |

## Verification
The bench builds the block with its default eight triggers and four channels. At these values both mask windows are full, so the first and last slots of each window (0x20, 0x3C, 0x40, 0x5C) can be probed at their real edges, and an input mask decoding into the wrong slot shows up directly. Four channels are few enough that a single gate pattern can close one channel while the other three stay open. This makes it possible to see, in the same run, that gating is selective and that the masks survive it.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;
  localparam int TRIG_N = 8;
  localparam int CHAN_N = 4;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam int OFF_CTRL    = 'h00;
  localparam int OFF_GATE    = 'h04;
  localparam int OFF_ACK     = 'h08;
  localparam int OFF_PULSE   = 'h0C;
  localparam int OFF_INMAP   = 'h20;
  localparam int OFF_OUTMAP  = 'h40;
  localparam int OFF_INSTAT  = 'h60;
  localparam int OFF_OUTSTAT = 'h64;

  // one-cycle strobes from the register file to the datapath
  typedef struct packed {
    logic [TRIG_N-1:0] ack;
    logic [CHAN_N-1:0] pulse;
  } strobes_t;
endpackage

// File: rtl/xtrig_regs.sv
module xtrig_regs
  import xtrig_pkg::*;
#(
  parameter int TRIG_W = TRIG_N,
  parameter int CHAN_W = CHAN_N,
  parameter int AW     = ADDR_W,
  parameter int DW     = DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [AW-1:0]     regAddr,
  input  logic [DW-1:0]     regWdata,
  output logic [DW-1:0]     regRdata,
  input  logic [TRIG_W-1:0] trigInStat,
  input  logic [TRIG_W-1:0] trigOutStat,
  output logic              cfgEn,
  output logic [CHAN_W-1:0] cfgGate,
  output logic [CHAN_W-1:0] inMask  [TRIG_W],
  output logic [CHAN_W-1:0] outMask [TRIG_W],
  output strobes_t          strobes
);
  localparam int IDX_W    = (TRIG_W > 1) ? $clog2(TRIG_W) : 1;
  localparam int BANK_LO  = IDX_W + 2;
  localparam int BANK_W   = AW - BANK_LO;
  localparam int IN_BANK  = OFF_INMAP >> BANK_LO;
  localparam int OUT_BANK = OFF_OUTMAP >> BANK_LO;

  logic [BANK_W-1:0] bankSel;
  logic [IDX_W-1:0]  slotIdx;
  logic              inBankHit;
  logic              outBankHit;

  assign bankSel    = regAddr[AW-1:BANK_LO];
  assign slotIdx    = regAddr[BANK_LO-1:2];
  assign inBankHit  = (bankSel == IN_BANK[BANK_W-1:0]);
  assign outBankHit = (bankSel == OUT_BANK[BANK_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgEn   <= 1'b0;
      cfgGate <= '1;
    end else if (regWe) begin
      if (regAddr == AW'(OFF_CTRL)) cfgEn   <= regWdata[0];
      if (regAddr == AW'(OFF_GATE)) cfgGate <= regWdata[CHAN_W-1:0];
    end
  end

  for (genvar g = 0; g < TRIG_W; g++) begin : gMask
    always_ff @(posedge clk) begin
      if (!rstN) begin
        inMask[g]  <= '0;
        outMask[g] <= '0;
      end else if (regWe && slotIdx == IDX_W'(g)) begin
        if (inBankHit)  inMask[g]  <= regWdata[CHAN_W-1:0];
        if (outBankHit) outMask[g] <= regWdata[CHAN_W-1:0];
      end
    end
  end

  always_comb begin
    strobes.ack   = (regWe && regAddr == AW'(OFF_ACK))   ? regWdata[TRIG_W-1:0] : '0;
    strobes.pulse = (regWe && regAddr == AW'(OFF_PULSE)) ? regWdata[CHAN_W-1:0] : '0;
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == AW'(OFF_CTRL))         regRdata[0]          = cfgEn;
    else if (regAddr == AW'(OFF_GATE))    regRdata[CHAN_W-1:0] = cfgGate;
    else if (regAddr == AW'(OFF_INSTAT))  regRdata[TRIG_W-1:0] = trigInStat;
    else if (regAddr == AW'(OFF_OUTSTAT)) regRdata[TRIG_W-1:0] = trigOutStat;
    else if (inBankHit)                   regRdata[CHAN_W-1:0] = inMask[slotIdx];
    else if (outBankHit)                  regRdata[CHAN_W-1:0] = outMask[slotIdx];
  end
endmodule

// File: rtl/xtrig_path.sv
module xtrig_path
  import xtrig_pkg::*;
#(
  parameter int TRIG_W = TRIG_N,
  parameter int CHAN_W = CHAN_N
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEn,
  input  logic [CHAN_W-1:0] cfgGate,
  input  logic [CHAN_W-1:0] inMask  [TRIG_W],
  input  logic [CHAN_W-1:0] outMask [TRIG_W],
  input  strobes_t          strobes,
  input  logic [TRIG_W-1:0] trigIn,
  input  logic [CHAN_W-1:0] chanIn,
  output logic [CHAN_W-1:0] chanOut,
  output logic [TRIG_W-1:0] trigOut
);
  logic [CHAN_W-1:0] srcUnion;
  logic [CHAN_W-1:0] rxEvents;
  logic [TRIG_W-1:0] setBits;

  // outgoing side: OR of masked inputs plus software pulses
  always_comb begin
    srcUnion = strobes.pulse;
    for (int i = 0; i < TRIG_W; i++) begin
      if (trigIn[i]) srcUnion = srcUnion | inMask[i];
    end
  end

  // incoming side passes the same gate before the output masks
  assign rxEvents = (chanIn | strobes.pulse) & cfgGate;

  for (genvar j = 0; j < TRIG_W; j++) begin : gOut
    assign setBits[j] = |(rxEvents & outMask[j]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanOut <= '0;
      trigOut <= '0;
    end else if (!cfgEn) begin
      chanOut <= '0;
      trigOut <= '0;
    end else begin
      chanOut <= srcUnion & cfgGate;
      trigOut <= (trigOut & ~strobes.ack) | setBits;
    end
  end
endmodule

// File: rtl/xtrig_iface.sv
module xtrig_iface
  import xtrig_pkg::*;
#(
  parameter int TRIG_W = TRIG_N,
  parameter int CHAN_W = CHAN_N,
  parameter int AW     = ADDR_W,
  parameter int DW     = DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [AW-1:0]     regAddr,
  input  logic [DW-1:0]     regWdata,
  output logic [DW-1:0]     regRdata,
  input  logic [TRIG_W-1:0] trigIn,
  output logic [TRIG_W-1:0] trigOut,
  input  logic [CHAN_W-1:0] chanIn,
  output logic [CHAN_W-1:0] chanOut
);
  logic              cfgEn;
  logic [CHAN_W-1:0] cfgGate;
  logic [CHAN_W-1:0] inMask  [TRIG_W];
  logic [CHAN_W-1:0] outMask [TRIG_W];
  strobes_t          strobes;
  logic [CHAN_W-1:0] pulseStb;

  assign pulseStb = strobes.pulse;

  xtrig_regs #(.TRIG_W(TRIG_W), .CHAN_W(CHAN_W), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .trigInStat(trigIn), .trigOutStat(trigOut),
    .cfgEn(cfgEn), .cfgGate(cfgGate), .inMask(inMask), .outMask(outMask),
    .strobes(strobes)
  );

  xtrig_path #(.TRIG_W(TRIG_W), .CHAN_W(CHAN_W)) u_path (
    .clk(clk), .rstN(rstN), .cfgEn(cfgEn), .cfgGate(cfgGate),
    .inMask(inMask), .outMask(outMask), .strobes(strobes),
    .trigIn(trigIn), .chanIn(chanIn), .chanOut(chanOut), .trigOut(trigOut)
  );
endmodule

// File: rtl/xtrig_iface_chk.sv
module xtrig_iface_chk
  import xtrig_pkg::*;
#(
  parameter int TRIG_W = TRIG_N,
  parameter int CHAN_W = CHAN_N,
  parameter int AW     = ADDR_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [AW-1:0]     regAddr,
  input logic [TRIG_W-1:0] trigIn,
  input logic [TRIG_W-1:0] trigOut,
  input logic [CHAN_W-1:0] chanOut,
  input logic              cfgEn,
  input logic [CHAN_W-1:0] cfgGate,
  input logic [CHAN_W-1:0] pulseStb
);
  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEn |=> (trigOut == '0 && chanOut == '0));

  // R4
  latched_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEn && !(regWe && regAddr == AW'(OFF_ACK)))
      |=> ((trigOut & $past(trigOut)) == $past(trigOut)));

  // R5
  gate_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((chanOut & ~$past(cfgGate)) == '0));

  // R2
  chan_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trigIn == '0 && pulseStb == '0) |=> (chanOut == '0));

  // R9
  ro_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && (regAddr == AW'(OFF_INSTAT) || regAddr == AW'(OFF_OUTSTAT)))
      |=> ($stable(cfgEn) && $stable(cfgGate)));
endmodule

bind xtrig_iface xtrig_iface_chk #(.TRIG_W(TRIG_W), .CHAN_W(CHAN_W), .AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .trigIn(trigIn),
  .trigOut(trigOut), .chanOut(chanOut), .cfgEn(cfgEn), .cfgGate(cfgGate),
  .pulseStb(pulseStb)
);

// File: tb/xtrig_iface_bench.sv
`timescale 1ns/100ps
module xtrig_iface_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [7:0]  trigIn = '0;
  logic [7:0]  trigOut;
  logic [3:0]  chanIn = '0;
  logic [3:0]  chanOut;

  int nChecks = 0;
  int nBad = 0;
  bit finished = 0;

  typedef struct {
    logic [3:0] chan;
    logic [7:0] trig;
    string      tag;
  } expItem_t;
  expItem_t expQ[$];

  // bench mirror of the programmed state
  logic       mEn = 1'b0;
  logic [3:0] mGate = 4'hF;
  logic [3:0] mIn [8];
  logic [3:0] mOut [8];
  logic [7:0] mTrig = '0;

  always #2 clk = ~clk;

  xtrig_iface u_xtrig_iface (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .trigIn(trigIn),
    .trigOut(trigOut), .chanIn(chanIn), .chanOut(chanOut)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares each cycle's outputs with the item queued for it
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      check(it.tag, {20'd0, chanOut, trigOut}, {20'd0, it.chan, it.trig});
    end
  end

  function automatic logic [31:0] readExp(logic [7:0] a);
    logic [31:0] v = '0;
    if (a == 8'h00) v[0] = mEn;
    else if (a == 8'h04) v[3:0] = mGate;
    else if (a == 8'h60) v[7:0] = trigIn;
    else if (a == 8'h64) v[7:0] = mTrig;
    else if (a >= 8'h20 && a <= 8'h3C) v[3:0] = mIn[(a - 8'h20) >> 2];
    else if (a >= 8'h40 && a <= 8'h5C) v[3:0] = mOut[(a - 8'h40) >> 2];
    return v;
  endfunction

  // expected result for the coming edge, then mirror the write
  task automatic stepModel(string tag);
    logic [7:0] ack, setB;
    logic [3:0] pulse, uni, ev;
    expItem_t it;
    ack   = (regWe && regAddr == 8'h08) ? regWdata[7:0] : 8'h00;
    pulse = (regWe && regAddr == 8'h0C) ? regWdata[3:0] : 4'h0;
    uni = pulse;
    for (int i = 0; i < 8; i++) if (trigIn[i]) uni |= mIn[i];
    ev = (chanIn | pulse) & mGate;
    setB = '0;
    for (int j = 0; j < 8; j++) setB[j] = |(ev & mOut[j]);
    it.chan = mEn ? (uni & mGate) : 4'h0;
    mTrig   = mEn ? ((mTrig & ~ack) | setB) : 8'h00;
    it.trig = mTrig;
    it.tag  = tag;
    expQ.push_back(it);
    if (regWe) begin
      if (regAddr == 8'h00) mEn = regWdata[0];
      else if (regAddr == 8'h04) mGate = regWdata[3:0];
      else if (regAddr >= 8'h20 && regAddr <= 8'h3C) mIn[(regAddr - 8'h20) >> 2] = regWdata[3:0];
      else if (regAddr >= 8'h40 && regAddr <= 8'h5C) mOut[(regAddr - 8'h40) >> 2] = regWdata[3:0];
    end
  endtask

  // driver: one clock with the given inputs
  task automatic cyc(logic [7:0] t, logic [3:0] c, logic we, logic [7:0] a,
                     logic [31:0] d, string tag);
    @(negedge clk);
    #0.5;
    trigIn = t; chanIn = c; regWe = we; regAddr = a; regWdata = d;
    stepModel(tag);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, string tag);
    cyc(trigIn, chanIn, 1'b1, a, d, tag);
  endtask

  task automatic rdChk(logic [7:0] a, string tag);
    logic [31:0] e;
    @(negedge clk);
    #0.5;
    regWe = 1'b0; regAddr = a;
    e = readExp(a);
    #0.5;
    check(tag, regRdata, e);
    stepModel(tag);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      nChecks++; nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mIn[i] = '0; mOut[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 outputs in reset", {20'd0, chanOut, trigOut}, 32'd0);
    #0.5 rstN = 1'b1;
    rdChk(8'h00, "R1 enable");
    rdChk(8'h04, "R1 gate");
    rdChk(8'h20, "R1 inmask0");
    rdChk(8'h5C, "R1 outmask7");

    // R8 mask windows at their edges
    wr(8'h20, 32'h1, "R8 wr in0");
    wr(8'h3C, 32'hA, "R8 wr in7");
    wr(8'h40, 32'h4, "R8 wr out0");
    wr(8'h5C, 32'h1, "R8 wr out7");
    rdChk(8'h20, "R8 in0");
    rdChk(8'h3C, "R8 in7");
    rdChk(8'h40, "R8 out0");
    rdChk(8'h5C, "R8 out7");
    rdChk(8'h24, "R8 in1");
    wr(8'h00, 32'h1, "R6 enable on");

    // R2 input mapping
    cyc(8'h01, 4'h0, 1'b0, 8'h00, 0, "R2 in0");
    cyc(8'h80, 4'h0, 1'b0, 8'h00, 0, "R2 in7");
    cyc(8'h81, 4'h0, 1'b0, 8'h00, 0, "R2 or");
    cyc(8'h02, 4'h0, 1'b0, 8'h00, 0, "R2 unmapped");
    rdChk(8'h60, "R8 raw input");

    // R3 output mapping, R4 latching
    cyc(8'h00, 4'h4, 1'b0, 8'h00, 0, "R3 ch2 to out0");
    cyc(8'h00, 4'h0, 1'b0, 8'h00, 0, "R4 hold");
    cyc(8'h00, 4'h1, 1'b0, 8'h00, 0, "R3 ch0 to out7");
    cyc(8'h00, 4'h0, 1'b0, 8'h00, 0, "R4 hold both");
    rdChk(8'h64, "R8 out status");
    wr(8'h08, 32'h00, "R4 ack zero");
    wr(8'h08, 32'h01, "R4 ack out0");
    cyc(8'h00, 4'h4, 1'b1, 8'h08, 32'h01, "R4 set wins");

    // R9 read-only and write-only offsets
    wr(8'h60, 32'h0, "R9 wr instat");
    wr(8'h64, 32'h0, "R9 wr outstat");
    rdChk(8'h00, "R9 enable kept");
    rdChk(8'h04, "R9 gate kept");
    rdChk(8'h08, "R9 ack reads 0");
    rdChk(8'h0C, "R9 pulse reads 0");

    // R5 gate
    wr(8'h08, 32'hFF, "R5 ack all");
    wr(8'h04, 32'hE, "R5 close ch0");
    cyc(8'h01, 4'h0, 1'b0, 8'h00, 0, "R5 out blocked");
    cyc(8'h80, 4'h0, 1'b0, 8'h00, 0, "R5 others open");
    cyc(8'h00, 4'h1, 1'b0, 8'h00, 0, "R5 in blocked");
    rdChk(8'h20, "R5 mask kept");
    wr(8'h04, 32'hF, "R5 reopen");
    cyc(8'h01, 4'h0, 1'b0, 8'h00, 0, "R5 restored");

    // R7 software pulse
    cyc(8'h00, 4'h0, 1'b1, 8'h0C, 32'h4, "R7 pulse ch2");
    cyc(8'h00, 4'h0, 1'b0, 8'h00, 0, "R7 single cycle");
    cyc(8'h00, 4'h0, 1'b1, 8'h0C, 32'h1, "R7 pulse ch0");

    // R6 global enable
    wr(8'h00, 32'h0, "R6 disable");
    cyc(8'h01, 4'h0, 1'b0, 8'h00, 0, "R6 cleared");
    cyc(8'h81, 4'h5, 1'b0, 8'h00, 0, "R6 held low");
    cyc(8'h00, 4'h0, 1'b1, 8'h0C, 32'hF, "R6 pulse off");
    cyc(8'h00, 4'h0, 1'b0, 8'h00, 0, "R6 idle");
    rdChk(8'h64, "R6 status clear");

    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule